// File: doc/BRIEF.md
# Memory Read-Data Error Checker

This block sits beside a memory traffic generator. It compares every read beat that comes back from the memory controller with the data the generator expected. A per-beat mismatch pulse reports the differing bits and the address of the beat. When checking is enabled, the block also does three things. It freezes the first mismatch, with its pattern, address, expected word and read word. It keeps a running OR of all mismatch bits. It classifies the first fault by reading the failing address a second time.

If the second read returns the expected word, the stored data was good and the fault happened on the read path, so the block reports a read error. If the second read still disagrees, the corruption is in the stored data and the block reports a write error. Three control pulses discard all error status: clear, continue and restart. Restart also rearms a watchdog. The watchdog raises a hang flag after a configurable number of cycles with no command issued and no read data returned.

The read-beat stream has no ready: the checker takes one beat every cycle. The re-read request channel is valid/ready. Valid and address hold steady until ready is sampled high. The re-read response is taken only in a cycle where the checker drives its response-ready high. A response presented at other times waits.

Top module: `rd_err_checker`

## Requirements
- R1: A beat is compared when `exp_valid` and `rd_valid` are both high in the same cycle. If any bit differs, the next cycle shows `err_pulse`=1, `err_bits` = expected XOR read, and `err_addr` = `rd_addr`. Otherwise `err_pulse`=0 and `err_bits`=0. This holds whatever the value of `chk_en`.
- R2: A beat with only one of `exp_valid` or `rd_valid` high is not compared and raises no pulse.
- R3: With `chk_en`=1, the first mismatch sets `first_vld`, `first_exp_vld` and `first_rd_vld` one cycle later. In the same cycle it stores the mismatch pattern, the address, the expected word and the read word.
- R4: Once `first_vld` is set, later mismatches do not change the first-error fields until a control pulse arrives.
- R5: With `chk_en`=1, every mismatch ORs its pattern into `sticky_bits` and sets `sticky_vld`.
- R6: `cmp_error` equals `sticky_vld` in every cycle.
- R7: In the cycle after the first capture, `rr_req_valid` rises with `rr_req_addr` = the failing address. The request is held until `rr_req_ready`. `rr_rsp_ready` then goes high. The cycle after a response is accepted, `type_vld`=1 and `type_read` = 1 if the response equals the stored expected word (read error), or 0 if it does not (write error).
- R8: A pulse on `err_clear`, `err_continue` or `restart` zeroes all first-error, sticky, compare-error and classification state, and abandons any re-read. It takes precedence over a mismatch in the same cycle, which is then not captured.
- R9: `hang` rises after `WDOG_LIMIT` consecutive cycles in which neither `cmd_issued` nor `rd_valid` is high. Either of those inputs restarts the count.
- R10: `hang` stays set until a `restart` pulse clears it. `err_clear` and `err_continue` leave it unchanged.
- R11: With `chk_en`=0, mismatches change no first-error or sticky state and start no re-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Enables capture, accumulation and classification |
| err_clear | input | 1 | Clear pulse for error status |
| err_continue | input | 1 | Continue pulse, discards error status |
| restart | input | 1 | Restart pulse, discards error status and rearms the watchdog |
| cmd_issued | input | 1 | A read or write command was sent this cycle |
| exp_valid | input | 1 | Expected word valid |
| exp_data | input | DW | Expected word |
| rd_valid | input | 1 | Read word valid |
| rd_data | input | DW | Read word from memory |
| rd_addr | input | AW | Address of the read word |
| rr_req_valid | output | 1 | Re-read request valid |
| rr_req_ready | input | 1 | Re-read request accepted |
| rr_req_addr | output | AW | Address to re-read |
| rr_rsp_valid | input | 1 | Re-read data valid |
| rr_rsp_ready | output | 1 | Checker is waiting for re-read data |
| rr_rsp_data | input | DW | Re-read data |
| err_pulse | output | 1 | Per-beat mismatch pulse |
| err_bits | output | DW | Per-beat mismatch pattern |
| err_addr | output | AW | Address of the mismatching beat |
| first_vld | output | 1 | First error held |
| first_bits | output | DW | First mismatch pattern |
| first_addr | output | AW | First mismatch address |
| first_exp_vld | output | 1 | First expected word held |
| first_exp | output | DW | Expected word at the first mismatch |
| first_rd_vld | output | 1 | First read word held |
| first_rd | output | DW | Read word at the first mismatch |
| sticky_vld | output | 1 | Any mismatch accumulated |
| sticky_bits | output | DW | OR of all mismatch patterns |
| cmp_error | output | 1 | Accumulated compare-error flag |
| type_vld | output | 1 | Classification result valid |
| type_read | output | 1 | 1 = read error, 0 = write error |
| hang | output | 1 | Watchdog hang flag |

## Verification
Some rules hold in every cycle, and the assertions check those. A reported pulse always carries a nonzero pattern. A beat that is valid on one side only raises no pulse. The first-error fields do not change while no control pulse is present. The sticky vector never loses a bit without a control pulse, and its valid flag agrees with it. A pending re-read request keeps its address until it is accepted. A classification result only follows an accepted response. The hang flag persists until restart.

Other behaviour depends on the data and needs the bench's scenarios. A stuck-bit fault must come out as a write error and a one-shot fault as a read error. Pulses must clear in the right order against a simultaneous mismatch. The watchdog must fire at exactly the configured idle count. The bench's cycle-by-cycle reference model shows these.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  typedef enum logic [1:0] {
    RR_IDLE = 2'd0,
    RR_REQ  = 2'd1,
    RR_WAIT = 2'd2,
    RR_DONE = 2'd3
  } rr_state_e;
endpackage

// File: rtl/rdc_compare.sv
module rdc_compare #(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exp_valid,
  input  logic [DW-1:0] exp_data,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic [AW-1:0] rd_addr,
  output logic          hit,
  output logic [DW-1:0] diff,
  output logic          err_pulse,
  output logic [DW-1:0] err_bits,
  output logic [AW-1:0] err_addr
);
  assign diff = exp_data ^ rd_data;
  assign hit  = exp_valid && rd_valid && (|diff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      err_bits  <= '0;
      err_addr  <= '0;
    end else begin
      err_pulse <= hit;
      err_bits  <= hit ? diff : '0;
      if (hit) err_addr <= rd_addr;
    end
  end

  assert_pulse_has_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (err_bits != '0));

  assert_one_sided_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(exp_valid && rd_valid) |=> !err_pulse);
endmodule

// File: rtl/rdc_capture.sv
module rdc_capture #(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_clear,
  input  logic          chk_en,
  input  logic          hit,
  input  logic [DW-1:0] diff,
  input  logic [DW-1:0] exp_data,
  input  logic [DW-1:0] rd_data,
  input  logic [AW-1:0] rd_addr,
  output logic          take,
  output logic          first_vld,
  output logic          first_exp_vld,
  output logic          first_rd_vld,
  output logic [DW-1:0] first_bits,
  output logic [AW-1:0] first_addr,
  output logic [DW-1:0] first_exp,
  output logic [DW-1:0] first_rd,
  output logic          sticky_vld,
  output logic [DW-1:0] sticky_bits
);
  logic accum;
  assign accum = chk_en && hit && !ctl_clear;
  assign take  = accum && !first_vld;

  always_ff @(posedge clk) begin
    if (!rst_n || ctl_clear) begin
      first_vld     <= 1'b0;
      first_exp_vld <= 1'b0;
      first_rd_vld  <= 1'b0;
      first_bits    <= '0;
      first_addr    <= '0;
      first_exp     <= '0;
      first_rd      <= '0;
      sticky_vld    <= 1'b0;
      sticky_bits   <= '0;
    end else begin
      if (take) begin
        first_vld     <= 1'b1;
        first_exp_vld <= 1'b1;
        first_rd_vld  <= 1'b1;
        first_bits    <= diff;
        first_addr    <= rd_addr;
        first_exp     <= exp_data;
        first_rd      <= rd_data;
      end
      if (accum) begin
        sticky_vld  <= 1'b1;
        sticky_bits <= sticky_bits | diff;
      end
    end
  end

  assert_first_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (first_vld && !ctl_clear) |=> ($stable(first_bits) && $stable(first_addr)
                                   && $stable(first_exp) && $stable(first_rd) && first_vld));

  assert_sticky_keeps_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_clear |=> ((sticky_bits & $past(sticky_bits)) == $past(sticky_bits)));

  assert_sticky_flag_agrees_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_vld == (sticky_bits != '0));
endmodule

// File: rtl/rdc_classify.sv
module rdc_classify
  import rdc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_clear,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] ref_data,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_data,
  output logic          type_vld,
  output logic          type_read
);
  rr_state_e state;

  assign req_valid = (state == RR_REQ);
  assign rsp_ready = (state == RR_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RR_IDLE;
      req_addr  <= '0;
      type_vld  <= 1'b0;
      type_read <= 1'b0;
    end else if (ctl_clear) begin
      state     <= RR_IDLE;
      type_vld  <= 1'b0;
      type_read <= 1'b0;
    end else begin
      case (state)
        RR_IDLE: if (start) begin
          state    <= RR_REQ;
          req_addr <= start_addr;
        end
        RR_REQ:  if (req_ready) state <= RR_WAIT;
        RR_WAIT: if (rsp_valid) begin
          state     <= RR_DONE;
          type_vld  <= 1'b1;
          type_read <= (rsp_data == ref_data);
        end
        default: state <= RR_DONE;
      endcase
    end
  end

  assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !ctl_clear) |=> (req_valid && $stable(req_addr)));

  assert_result_after_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(type_vld) |-> $past(rsp_valid && rsp_ready));
endmodule

// File: rtl/rdc_watchdog.sv
module rdc_watchdog #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic activity,
  output logic hang
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      idle_cnt <= '0;
      hang     <= 1'b0;
    end else if (activity) begin
      idle_cnt <= '0;
    end else if (!hang) begin
      if (idle_cnt == CW'(LIMIT - 1)) hang <= 1'b1;
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assert_hang_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hang && !restart) |=> hang);

  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !hang);

  assert_activity_blocks_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (activity && !hang) |=> !hang);
endmodule

// File: rtl/rd_err_checker.sv
module rd_err_checker #(
  parameter int DW         = 32,
  parameter int AW         = 16,
  parameter int WDOG_LIMIT = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic          err_clear,
  input  logic          err_continue,
  input  logic          restart,
  input  logic          cmd_issued,
  input  logic          exp_valid,
  input  logic [DW-1:0] exp_data,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic [AW-1:0] rd_addr,
  output logic          rr_req_valid,
  input  logic          rr_req_ready,
  output logic [AW-1:0] rr_req_addr,
  input  logic          rr_rsp_valid,
  output logic          rr_rsp_ready,
  input  logic [DW-1:0] rr_rsp_data,
  output logic          err_pulse,
  output logic [DW-1:0] err_bits,
  output logic [AW-1:0] err_addr,
  output logic          first_vld,
  output logic [DW-1:0] first_bits,
  output logic [AW-1:0] first_addr,
  output logic          first_exp_vld,
  output logic [DW-1:0] first_exp,
  output logic          first_rd_vld,
  output logic [DW-1:0] first_rd,
  output logic          sticky_vld,
  output logic [DW-1:0] sticky_bits,
  output logic          cmp_error,
  output logic          type_vld,
  output logic          type_read,
  output logic          hang
);
  logic          ctl_clear;
  logic          hit;
  logic [DW-1:0] diff;
  logic          take;

  assign ctl_clear = err_clear || err_continue || restart;
  assign cmp_error = sticky_vld;

  rdc_compare #(.DW(DW), .AW(AW)) u_compare (
    .clk(clk), .rst_n(rst_n),
    .exp_valid(exp_valid), .exp_data(exp_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_addr(rd_addr),
    .hit(hit), .diff(diff),
    .err_pulse(err_pulse), .err_bits(err_bits), .err_addr(err_addr)
  );

  rdc_capture #(.DW(DW), .AW(AW)) u_capture (
    .clk(clk), .rst_n(rst_n), .ctl_clear(ctl_clear), .chk_en(chk_en),
    .hit(hit), .diff(diff), .exp_data(exp_data), .rd_data(rd_data), .rd_addr(rd_addr),
    .take(take),
    .first_vld(first_vld), .first_exp_vld(first_exp_vld), .first_rd_vld(first_rd_vld),
    .first_bits(first_bits), .first_addr(first_addr),
    .first_exp(first_exp), .first_rd(first_rd),
    .sticky_vld(sticky_vld), .sticky_bits(sticky_bits)
  );

  rdc_classify #(.DW(DW), .AW(AW)) u_classify (
    .clk(clk), .rst_n(rst_n), .ctl_clear(ctl_clear),
    .start(take), .start_addr(rd_addr), .ref_data(first_exp),
    .req_valid(rr_req_valid), .req_ready(rr_req_ready), .req_addr(rr_req_addr),
    .rsp_valid(rr_rsp_valid), .rsp_ready(rr_rsp_ready), .rsp_data(rr_rsp_data),
    .type_vld(type_vld), .type_read(type_read)
  );

  rdc_watchdog #(.LIMIT(WDOG_LIMIT)) u_watchdog (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .activity(cmd_issued || rd_valid), .hang(hang)
  );

  assert_result_needs_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    type_vld |-> first_vld);

  assert_disabled_no_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_en && !ctl_clear) |=> ($stable(sticky_bits) && $stable(first_vld)));

  assert_clear_wipes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clear |=> (!first_vld && !sticky_vld && !type_vld && !rr_req_valid));
endmodule

// File: tb/rd_err_checker_bench.sv
module rd_err_checker_bench;
  localparam int DW = 32;
  localparam int AW = 16;
  localparam int LIM = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_en = 1'b0, err_clear = 1'b0, err_continue = 1'b0, restart = 1'b0;
  logic cmd_issued = 1'b1;
  logic exp_valid = 1'b0, rd_valid = 1'b0;
  logic [DW-1:0] exp_data = '0, rd_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic rr_req_valid, rr_req_ready, rr_rsp_valid, rr_rsp_ready;
  logic [AW-1:0] rr_req_addr;
  logic [DW-1:0] rr_rsp_data;
  logic err_pulse, first_vld, first_exp_vld, first_rd_vld, sticky_vld, cmp_error;
  logic type_vld, type_read, hang;
  logic [DW-1:0] err_bits, first_bits, first_exp, first_rd, sticky_bits;
  logic [AW-1:0] err_addr, first_addr;

  always #5 clk = ~clk;

  rd_err_checker #(.DW(DW), .AW(AW), .WDOG_LIMIT(LIM)) u_rd_err_checker (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .err_clear(err_clear),
    .err_continue(err_continue), .restart(restart), .cmd_issued(cmd_issued),
    .exp_valid(exp_valid), .exp_data(exp_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .rr_req_valid(rr_req_valid), .rr_req_ready(rr_req_ready), .rr_req_addr(rr_req_addr),
    .rr_rsp_valid(rr_rsp_valid), .rr_rsp_ready(rr_rsp_ready), .rr_rsp_data(rr_rsp_data),
    .err_pulse(err_pulse), .err_bits(err_bits), .err_addr(err_addr),
    .first_vld(first_vld), .first_bits(first_bits), .first_addr(first_addr),
    .first_exp_vld(first_exp_vld), .first_exp(first_exp),
    .first_rd_vld(first_rd_vld), .first_rd(first_rd),
    .sticky_vld(sticky_vld), .sticky_bits(sticky_bits), .cmp_error(cmp_error),
    .type_vld(type_vld), .type_read(type_read), .hang(hang)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit            m_pulse = 0, m_fv = 0, m_sv = 0, m_tv = 0, m_tr = 0, m_hang = 0;
  logic [DW-1:0] m_bits = '0, m_fbits = '0, m_fexp = '0, m_frd = '0, m_sticky = '0;
  logic [AW-1:0] m_addr = '0, m_faddr = '0, m_raddr = '0;
  int            m_phase = 0;   // 0 idle, 1 requesting, 2 awaiting data, 3 decided
  int            m_idle = 0;
  bit            started = 0;

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_pulse <= 0; m_bits <= '0; m_addr <= '0; m_fv <= 0; m_fbits <= '0; m_faddr <= '0;
      m_fexp <= '0; m_frd <= '0; m_sv <= 0; m_sticky <= '0; m_phase <= 0; m_raddr <= '0;
      m_tv <= 0; m_tr <= 0; m_idle <= 0; m_hang <= 0;
    end else begin
      bit mism;
      bit ctl;
      mism = exp_valid && rd_valid && (exp_data != rd_data);
      ctl  = err_clear || err_continue || restart;
      m_pulse <= mism;
      m_bits  <= mism ? (exp_data ^ rd_data) : '0;
      if (mism) m_addr <= rd_addr;
      if (ctl) begin
        m_fv <= 0; m_fbits <= '0; m_faddr <= '0; m_fexp <= '0; m_frd <= '0;
        m_sv <= 0; m_sticky <= '0; m_phase <= 0; m_tv <= 0; m_tr <= 0;
      end else begin
        if (chk_en && mism) begin
          m_sv <= 1; m_sticky <= m_sticky | (exp_data ^ rd_data);
          if (!m_fv) begin
            m_fv <= 1; m_fbits <= exp_data ^ rd_data; m_faddr <= rd_addr;
            m_fexp <= exp_data; m_frd <= rd_data; m_phase <= 1; m_raddr <= rd_addr;
          end
        end
        if (m_phase == 1 && rr_req_ready) m_phase <= 2;
        if (m_phase == 2 && rr_rsp_valid) begin
          m_phase <= 3; m_tv <= 1; m_tr <= (rr_rsp_data == m_fexp);
        end
      end
      if (restart) begin
        m_idle <= 0; m_hang <= 0;
      end else if (cmd_issued || rd_valid) begin
        m_idle <= 0;
      end else if (!m_hang) begin
        m_idle <= m_idle + 1;
        if (m_idle + 1 >= LIM) m_hang <= 1;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check(err_pulse == m_pulse, "R1 err_pulse", err_pulse, m_pulse);
      check(err_bits == m_bits, "R1 err_bits", err_bits, m_bits);
      if (m_pulse) check(err_addr == m_addr, "R1 err_addr", err_addr, m_addr);
      check(first_vld == m_fv && first_exp_vld == m_fv && first_rd_vld == m_fv,
            "R3 first valids", {first_vld, first_exp_vld, first_rd_vld}, {m_fv, m_fv, m_fv});
      check(first_bits == m_fbits && first_addr == m_faddr, "R3 first pattern/addr",
            {first_bits, first_addr}, {m_fbits, m_faddr});
      check(first_exp == m_fexp && first_rd == m_frd, "R3 first words",
            {first_exp, first_rd}, {m_fexp, m_frd});
      check(sticky_vld == m_sv && sticky_bits == m_sticky, "R5 sticky",
            {sticky_vld, sticky_bits}, {m_sv, m_sticky});
      check(cmp_error == m_sv, "R6 cmp_error", cmp_error, m_sv);
      check(rr_req_valid == (m_phase == 1) && rr_rsp_ready == (m_phase == 2), "R7 handshake",
            {rr_req_valid, rr_rsp_ready}, {m_phase == 1, m_phase == 2});
      if (m_phase == 1) check(rr_req_addr == m_raddr, "R7 req addr", rr_req_addr, m_raddr);
      check(type_vld == m_tv && type_read == m_tr, "R7 type",
            {type_vld, type_read}, {m_tv, m_tr});
      check(hang == m_hang, "R9 hang", hang, m_hang);
    end
  end

  // ---------------- re-read responder ----------------
  bit            rr_transient = 0;
  logic [DW-1:0] rr_ref = '0, rr_fault = '0;
  int  pend = -1, stall = 0;
  bit  req_fired = 0, rsp_fired = 0;
  initial begin
    rr_req_ready = 0; rr_rsp_valid = 0; rr_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (rsp_fired) rr_rsp_valid = 0;
      if (req_fired) pend = 2;
      else if (pend > 0) pend--;
      else if (pend == 0) begin
        rr_rsp_valid = 1;
        rr_rsp_data  = rr_transient ? rr_ref : (rr_ref ^ rr_fault);
        pend = -1;
      end
      if (rr_req_valid) begin stall++; rr_req_ready = (stall >= 3); end
      else begin stall = 0; rr_req_ready = 0; end
      req_fired = rr_req_valid && rr_req_ready;
      rsp_fired = rr_rsp_valid && rr_rsp_ready;
    end
  end

  // ---------------- stimulus ----------------
  task automatic beat(input logic [DW-1:0] e, input logic [DW-1:0] r, input logic [AW-1:0] a,
                      input bit ev, input bit rv);
    @(negedge clk);
    exp_valid = ev; rd_valid = rv; exp_data = e; rd_data = r; rd_addr = a;
    @(negedge clk);
    exp_valid = 0; rd_valid = 0;
  endtask

  task automatic pulse_ctl(input int which);
    @(negedge clk);
    if (which == 0) err_clear = 1; else if (which == 1) err_continue = 1; else restart = 1;
    @(negedge clk);
    err_clear = 0; err_continue = 0; restart = 0;
  endtask

  task automatic wait_type();
    for (int i = 0; i < 40 && !type_vld; i++) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog timeout actual=%0d expected<20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!first_vld && !hang && !err_pulse && !type_vld, "R3 R9 reset state",
          {first_vld, hang, err_pulse, type_vld}, 0);

    // R2: one-sided beats
    beat(32'hAAAA_0000, 32'h0000_5555, 16'h10, 1, 0);
    check(err_pulse == 0, "R2 exp-only beat", err_pulse, 0);
    beat(32'hAAAA_0000, 32'h0000_5555, 16'h11, 0, 1);
    check(err_pulse == 0, "R2 read-only beat", err_pulse, 0);

    // R11 with R1: checking disabled
    beat(32'h1234_5678, 32'h1234_567D, 16'h20, 1, 1);
    check(err_pulse == 1 && err_bits == 32'h5 && err_addr == 16'h20, "R1 pulse with chk off",
          {err_pulse, err_bits, err_addr}, {1'b1, 32'h5, 16'h20});
    repeat (3) @(negedge clk);
    check(!first_vld && sticky_bits == 0 && !rr_req_valid, "R11 disabled no capture",
          {first_vld, sticky_bits, rr_req_valid}, 0);

    // persistent stuck-bit fault -> write error
    chk_en = 1;
    rr_transient = 0; rr_ref = 32'hCAFE_0001; rr_fault = 32'h10;
    beat(32'hCAFE_0001, 32'hCAFE_0011, 16'h0100, 1, 1);
    check(first_vld && first_bits == 32'h10 && first_addr == 16'h0100, "R3 capture",
          {first_bits, first_addr}, {32'h10, 16'h0100});
    beat(32'h0000_00F0, 32'h0000_00F3, 16'h0104, 1, 1);
    check(first_bits == 32'h10 && first_addr == 16'h0100 && first_rd == 32'hCAFE_0011,
          "R4 first frozen", {first_bits, first_addr}, {32'h10, 16'h0100});
    check(sticky_bits == 32'h13 && cmp_error, "R5 R6 sticky or", {cmp_error, sticky_bits},
          {1'b1, 32'h13});
    wait_type();
    @(negedge clk);
    check(type_vld && type_read == 0, "R7 stuck fault is write error", {type_vld, type_read}, 2'b10);

    pulse_ctl(0);
    check(!first_vld && !sticky_vld && !cmp_error && !type_vld, "R8 clear wipes",
          {first_vld, sticky_vld, cmp_error, type_vld}, 0);

    // transient fault -> read error
    rr_transient = 1; rr_ref = 32'h0BAD_F00D;
    beat(32'h0BAD_F00D, 32'h0BAD_F08D, 16'h0200, 1, 1);
    wait_type();
    @(negedge clk);
    check(type_vld && type_read == 1, "R7 transient fault is read error", {type_vld, type_read}, 2'b11);
    pulse_ctl(1);
    check(!first_vld && !type_vld && sticky_bits == 0, "R8 continue wipes",
          {first_vld, type_vld, sticky_bits}, 0);

    // R8: control pulse coincident with mismatch
    @(negedge clk);
    err_clear = 1; exp_valid = 1; rd_valid = 1; exp_data = 32'h1; rd_data = 32'h3; rd_addr = 16'h300;
    @(negedge clk);
    err_clear = 0; exp_valid = 0; rd_valid = 0;
    check(err_pulse && !first_vld && !sticky_vld && !rr_req_valid, "R8 clear beats mismatch",
          {err_pulse, first_vld, sticky_vld, rr_req_valid}, 4'b1000);

    // restart clears capture, leaving request pending aborted before grant
    rr_transient = 0; rr_ref = 32'h55; rr_fault = 32'h1;
    beat(32'h55, 32'h54, 16'h0400, 1, 1);
    pulse_ctl(2);
    check(!first_vld && !rr_req_valid && !sticky_vld, "R8 restart wipes",
          {first_vld, rr_req_valid, sticky_vld}, 0);
    repeat (4) @(negedge clk);

    // watchdog R9 / R10
    cmd_issued = 0;
    repeat (LIM - 1) @(negedge clk);
    check(hang == 0, "R9 no hang before limit", hang, 0);
    @(negedge clk);
    check(hang == 1, "R9 hang at limit", hang, 1);
    cmd_issued = 1;
    pulse_ctl(0);
    pulse_ctl(1);
    check(hang == 1, "R10 clear/continue keep hang", hang, 1);
    pulse_ctl(2);
    check(hang == 0, "R10 restart clears hang", hang, 0);
    cmd_issued = 0;
    repeat (LIM / 2) @(negedge clk);
    beat(32'h7, 32'h7, 16'h0, 1, 1);
    repeat (LIM - 3) @(negedge clk);
    check(hang == 0, "R9 read beat restarts count", hang, 0);
    cmd_issued = 1;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule